// File: doc/BRIEF.md
# Looping Wide-Word Pattern Sequencer

This block plays a stored program of wide output words onto a registered 72-bit bus that drives a device under test. Every bit of the bus can change on any clock cycle. The program sits in an internal instruction memory. A host fills that memory one byte at a time through a write port, and may do so only while the sequencer is idle.

Besides plain output words with hold counts, the instruction set has counted loops and subroutine calls. Loop counters and return addresses share one hardware stack of eight frames. Loops may therefore nest inside calls, and calls may nest inside loops, up to that depth. A run pulse starts execution at address 0. A HALT instruction or the stop input ends the run. The bus keeps its last word while the sequencer is idle. A stack overflow or underflow ends the run and raises an error flag.

Top module: `pattern_seq`

## Requirements
- R1: After reset the bus is all zeros, and busy and error are both low.
- R2: While idle, a host write stores host_byte into byte lane host_lane of instruction host_addr, where lane k holds bits 8k+7..8k of a 96-bit word. The word layout is: bits 71..0 are the output word, bits 87..72 the operand, and bits 95..88 the opcode. The opcodes are HALT=0, OUT=1, LOOP=2, ENDLOOP=3, CALL=4 and RET=5.
- R3: Host writes made while busy is high have no effect on the stored program.
- R4: A run pulse while idle raises busy on the next edge, clears the error flag and starts at address 0. The first instruction takes effect on the edge after that.
- R5: OUT with operand N puts its word on the bus in the cycle after it executes and holds it for exactly N+1 cycles. Back-to-back OUT instructions with N=0 change the bus on every cycle.
- R6: LOOP, ENDLOOP, CALL, RET and HALT each take one cycle and leave the bus unchanged.
- R7: LOOP n pushes a frame. The body up to the matching ENDLOOP then runs n+1 times, and the frame is popped on exit.
- R8: CALL pushes the address of the next instruction and jumps to the target in operand bits 5..0. RET pops that address and resumes there. Calls nest.
- R9: A push onto a full eight-frame stack sets the error flag and ends the run.
- R10: ENDLOOP or RET with an empty stack sets the error flag and ends the run.
- R11: The stop input ends a run on the next edge. While idle, the bus holds its last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host byte write strobe |
| host_addr | input | 6 | Instruction index to write |
| host_lane | input | 4 | Byte lane within the instruction |
| host_byte | input | 8 | Byte to store |
| run_i | input | 1 | Start execution at address 0 |
| stop_i | input | 1 | Stop execution |
| busy_o | output | 1 | Program is running |
| err_o | output | 1 | Last run ended on a stack fault |
| pat_o | output | 72 | Registered output pattern |

## Verification
The first pattern is a straight run of OUT words with mixed hold counts. It separates an off-by-one in the hold count from correct N+1 timing, and shows that single-cycle words are not merged. A counted loop around two words shows whether the body runs n+1 times, and whether the ENDLOOP cycle holds the bus rather than skipping a cycle. A loop that calls a subroutine, which in turn calls another, separates correct return-address stacking from a stack that loses frames across nesting. Self-recursion and a bare RET drive the overflow and underflow paths. A write made during a run, followed by a restart, shows whether the program stayed intact.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int OPF_W = 8;

    typedef enum logic [OPF_W-1:0] {
        OP_HALT    = 8'd0,
        OP_OUT     = 8'd1,
        OP_LOOP    = 8'd2,
        OP_ENDLOOP = 8'd3,
        OP_CALL    = 8'd4,
        OP_RET     = 8'd5
    } seq_op_e;

    typedef enum logic [2:0] {
        STK_NONE,
        STK_PUSH,
        STK_POP,
        STK_DECR,
        STK_CLEAR
    } stk_op_e;

endpackage

// File: rtl/seq_progmem.sv
module seq_progmem #(
    parameter int AW      = 6,
    parameter int BYTES   = 12,
    parameter int LANE_W  = 4,
    localparam int DEPTH  = 1 << AW,
    localparam int WORD_W = BYTES * 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [LANE_W-1:0] wr_lane,
    input  logic [7:0]        wr_byte,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int b = 0; b < BYTES; b++) begin
            if (wr_en && wr_lane == LANE_W'(b)) begin
                mem[wr_addr][b*8 +: 8] <= wr_byte;
            end
        end
    end

    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/seq_stack.sv
module seq_stack
    import seq_pkg::*;
#(
    parameter int AW    = 6,
    parameter int CW    = 16,
    parameter int DEPTH = 8,
    localparam int SP_W  = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_op_e       op,
    input  logic [AW-1:0] push_addr,
    input  logic [CW-1:0] push_cnt,
    output logic [AW-1:0] top_addr,
    output logic [CW-1:0] top_cnt,
    output logic          empty,
    output logic          full
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
    } frame_t;

    typedef struct packed {
        frame_t [DEPTH-1:0] ent;
        logic   [SP_W-1:0]  sp;
    } stk_t;

    stk_t s_d, s_q;
    logic [IDX_W-1:0] top_idx;

    assign top_idx  = IDX_W'(s_q.sp - SP_W'(1));
    assign top_addr = s_q.ent[top_idx].addr;
    assign top_cnt  = s_q.ent[top_idx].cnt;
    assign empty    = (s_q.sp == '0);
    assign full     = (s_q.sp == SP_W'(DEPTH));

    always_comb begin
        s_d = s_q;
        case (op)
            STK_PUSH: begin
                s_d.ent[IDX_W'(s_q.sp)] = '{addr: push_addr, cnt: push_cnt};
                s_d.sp = s_q.sp + SP_W'(1);
            end
            STK_POP:   s_d.sp = s_q.sp - SP_W'(1);
            STK_DECR:  s_d.ent[top_idx].cnt = s_q.ent[top_idx].cnt - CW'(1);
            STK_CLEAR: s_d.sp = '0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_PUSH) |-> !full);

    a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_POP || op == STK_DECR) |-> !empty);

endmodule

// File: rtl/pattern_seq.sv
module pattern_seq
    import seq_pkg::*;
#(
    parameter int DATA_W  = 72,
    parameter int OPER_W  = 16,
    parameter int AW      = 6,
    parameter int STK_DEP = 8,
    localparam int BYTES   = (DATA_W + OPER_W + OPF_W + 7) / 8,
    localparam int INSTR_W = BYTES * 8,
    localparam int LANE_W  = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [LANE_W-1:0] host_lane,
    input  logic [7:0]        host_byte,
    input  logic              run_i,
    input  logic              stop_i,
    output logic              busy_o,
    output logic              err_o,
    output logic [DATA_W-1:0] pat_o
);

    typedef struct packed {
        logic              busy;
        logic              err;
        logic [AW-1:0]     pc;
        logic              hold;
        logic [OPER_W-1:0] rem;
        logic [DATA_W-1:0] pat;
    } st_t;

    st_t s_d, s_q;

    logic [INSTR_W-1:0] inst;
    logic [DATA_W-1:0]  i_data;
    logic [OPER_W-1:0]  i_opr;
    logic [OPF_W-1:0]   i_op;
    stk_op_e            stk_op;
    logic [AW-1:0]      push_addr, top_addr;
    logic [OPER_W-1:0]  push_cnt, top_cnt;
    logic               stk_empty, stk_full;

    seq_progmem #(.AW(AW), .BYTES(BYTES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .wr_en   (host_we && !s_q.busy),
        .wr_addr (host_addr),
        .wr_lane (host_lane),
        .wr_byte (host_byte),
        .rd_addr (s_q.pc),
        .rd_word (inst)
    );

    seq_stack #(.AW(AW), .CW(OPER_W), .DEPTH(STK_DEP)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (stk_op),
        .push_addr (push_addr),
        .push_cnt  (push_cnt),
        .top_addr  (top_addr),
        .top_cnt   (top_cnt),
        .empty     (stk_empty),
        .full      (stk_full)
    );

    assign i_data = inst[DATA_W-1:0];
    assign i_opr  = inst[DATA_W +: OPER_W];
    assign i_op   = inst[INSTR_W-1 -: OPF_W];

    always_comb begin
        s_d       = s_q;
        stk_op    = STK_NONE;
        push_addr = s_q.pc + AW'(1);
        push_cnt  = '0;
        if (s_q.busy) begin
            if (stop_i) begin
                s_d.busy = 1'b0;
                s_d.hold = 1'b0;
            end else begin
                case (i_op)
                    OP_OUT: begin
                        if (!s_q.hold) begin
                            s_d.pat = i_data;
                            if (i_opr == '0) s_d.pc = s_q.pc + AW'(1);
                            else begin
                                s_d.hold = 1'b1;
                                s_d.rem  = i_opr;
                            end
                        end else if (s_q.rem == OPER_W'(1)) begin
                            s_d.hold = 1'b0;
                            s_d.pc   = s_q.pc + AW'(1);
                        end else begin
                            s_d.rem = s_q.rem - OPER_W'(1);
                        end
                    end
                    OP_LOOP, OP_CALL: begin
                        if (stk_full) begin
                            s_d.err  = 1'b1;
                            s_d.busy = 1'b0;
                        end else begin
                            stk_op = STK_PUSH;
                            if (i_op == OP_LOOP) begin
                                push_cnt = i_opr;
                                s_d.pc   = s_q.pc + AW'(1);
                            end else begin
                                s_d.pc = i_opr[AW-1:0];
                            end
                        end
                    end
                    OP_ENDLOOP, OP_RET: begin
                        if (stk_empty) begin
                            s_d.err  = 1'b1;
                            s_d.busy = 1'b0;
                        end else if (i_op == OP_ENDLOOP && top_cnt != '0) begin
                            stk_op = STK_DECR;
                            s_d.pc = top_addr;
                        end else begin
                            stk_op = STK_POP;
                            s_d.pc = (i_op == OP_RET) ? top_addr : s_q.pc + AW'(1);
                        end
                    end
                    default: s_d.busy = 1'b0;
                endcase
            end
        end else if (run_i) begin
            s_d.busy = 1'b1;
            s_d.err  = 1'b0;
            s_d.pc   = '0;
            s_d.hold = 1'b0;
            stk_op   = STK_CLEAR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign err_o  = s_q.err;
    assign pat_o  = s_q.pat;

    a_r11_stop_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && stop_i) |=> !busy_o);

    a_r11_idle_holds_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(pat_o));

    a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && s_q.hold && s_q.rem != OPER_W'(1) && !stop_i) |=> $stable(pat_o));

    a_r9_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !busy_o);

    a_r4_run_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && run_i) |=> (busy_o && !err_o));

endmodule

// File: tb/sim_pattern_seq.sv
module sim_pattern_seq;

    localparam logic [7:0] HALT = 8'd0, OUT = 8'd1, LOOP = 8'd2,
                           ENDL = 8'd3, CALL = 8'd4, RET  = 8'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [3:0]  host_lane = '0;
    logic [7:0]  host_byte = '0;
    logic        run_i = 1'b0;
    logic        stop_i = 1'b0;
    logic        busy_o, err_o;
    logic [71:0] pat_o;

    int          n_chk = 0;
    int          n_err = 0;
    logic        armed = 1'b0;
    string       tag = "R5";
    logic [71:0] exp_q[$];

    always #10 clk = ~clk;

    pattern_seq u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_lane(host_lane), .host_byte(host_byte), .run_i(run_i),
        .stop_i(stop_i), .busy_o(busy_o), .err_o(err_o), .pat_o(pat_o)
    );

    task automatic check(input logic ok, input string req,
                         input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (armed) begin
            if (exp_q.size() > 0) begin
                logic [71:0] e;
                e = exp_q.pop_front();
                check(pat_o === e, tag, pat_o, e);
            end
            if (exp_q.size() == 0) armed = 1'b0;
        end
    end

    task automatic put(input int a, input logic [7:0] op,
                       input logic [15:0] opr, input logic [71:0] d);
        logic [95:0] w;
        w = {op, opr, d};
        for (int b = 0; b < 12; b++) begin
            @(negedge clk);
            host_we = 1'b1; host_addr = 6'(a); host_lane = 4'(b);
            host_byte = w[b*8 +: 8];
        end
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic expect_n(input logic [71:0] w, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(w);
    endtask

    task automatic pulse_run();
        @(negedge clk); run_i = 1'b1;
        @(negedge clk); run_i = 1'b0;
    endtask

    task automatic run_scored();
        @(negedge clk); run_i = 1'b1;
        @(posedge clk); #1 run_i = 1'b0;
        @(posedge clk); #1 armed = 1'b1;
        wait (armed == 1'b0);
        repeat (2) @(negedge clk);
        check(busy_o == 1'b0, {tag, " busy after HALT"}, 72'(busy_o), 72'd0);
    endtask

    localparam logic [71:0] WA = 72'hA1_0000_0000_0000_00A1;
    localparam logic [71:0] WB = 72'hB2_FFFF_0000_1234_55B2;
    localparam logic [71:0] WC = 72'hC3_8000_0000_0000_0001;
    localparam logic [71:0] WP = 72'h11_1111_1111_1111_1111;
    localparam logic [71:0] WQ = 72'h22_2222_2222_2222_2222;
    localparam logic [71:0] WR = 72'h33_3333_3333_3333_3333;

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pat_o == '0, "R1 bus", pat_o, 72'd0);
        check(busy_o == 1'b0, "R1 busy", 72'(busy_o), 72'd0);
        check(err_o == 1'b0, "R1 err", 72'(err_o), 72'd0);
        rst_n = 1'b1;

        // R2 R5 R6: straight words with hold counts
        put(0, OUT, 16'd0, WA);
        put(1, OUT, 16'd2, WB);
        put(2, OUT, 16'd0, WC);
        put(3, HALT, 16'd0, '0);
        tag = "R2/R5";
        expect_n(WA, 1); expect_n(WB, 3); expect_n(WC, 1);
        expect_n(WC, 1);                      // HALT cycle (R6)
        run_scored();
        repeat (5) @(negedge clk);
        check(pat_o == WC, "R11 idle hold", pat_o, WC);

        // R7 counted loop
        put(0, OUT, 16'd0, WP);
        put(1, LOOP, 16'd2, '0);
        put(2, OUT, 16'd0, WA);
        put(3, OUT, 16'd1, WB);
        put(4, ENDL, 16'd0, '0);
        put(5, OUT, 16'd0, WC);
        put(6, HALT, 16'd0, '0);
        tag = "R7";
        expect_n(WP, 2);
        for (int i = 0; i < 3; i++) begin
            expect_n(WA, 1); expect_n(WB, 3);
        end
        expect_n(WC, 2);
        run_scored();

        // R8 nested calls inside a loop
        put(0, OUT, 16'd0, WP);
        put(1, LOOP, 16'd1, '0);
        put(2, CALL, 16'd10, '0);
        put(3, ENDL, 16'd0, '0);
        put(4, HALT, 16'd0, '0);
        put(10, OUT, 16'd0, WQ);
        put(11, CALL, 16'd20, '0);
        put(12, RET, 16'd0, '0);
        put(20, OUT, 16'd1, WR);
        put(21, RET, 16'd0, '0);
        tag = "R8";
        expect_n(WP, 3);
        expect_n(WQ, 2); expect_n(WR, 5);
        expect_n(WR, 1);
        expect_n(WQ, 2); expect_n(WR, 5);
        expect_n(WR, 1);
        run_scored();

        // R9 overflow by self-recursion
        put(0, CALL, 16'd0, '0);
        pulse_run();
        repeat (20) @(negedge clk);
        check(err_o == 1'b1, "R9 err", 72'(err_o), 72'd1);
        check(busy_o == 1'b0, "R9 busy", 72'(busy_o), 72'd0);
        check(pat_o == WR, "R9 bus held", pat_o, WR);

        // R4 run clears the error flag
        put(0, OUT, 16'd0, WA);
        put(1, HALT, 16'd0, '0);
        tag = "R4";
        expect_n(WA, 2);
        run_scored();
        check(err_o == 1'b0, "R4 err cleared", 72'(err_o), 72'd0);

        // R10 underflow
        put(0, RET, 16'd0, '0);
        pulse_run();
        repeat (4) @(negedge clk);
        check(err_o == 1'b1, "R10 err", 72'(err_o), 72'd1);
        check(busy_o == 1'b0, "R10 busy", 72'(busy_o), 72'd0);

        // R11 stop input, R3 writes ignored while busy
        put(0, LOOP, 16'hFFFF, '0);
        put(1, OUT, 16'd0, WB);
        put(2, OUT, 16'd0, WC);
        put(3, ENDL, 16'd0, '0);
        pulse_run();
        repeat (10) @(negedge clk);
        check(busy_o == 1'b1, "R11 running", 72'(busy_o), 72'd1);
        @(negedge clk);
        host_we = 1'b1; host_addr = 6'd0; host_lane = 4'd11; host_byte = HALT;
        @(negedge clk);
        host_we = 1'b0;
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check(busy_o == 1'b0, "R11 stopped", 72'(busy_o), 72'd0);
        begin
            logic [71:0] held;
            held = pat_o;
            repeat (5) @(negedge clk);
            check(pat_o == held, "R11 bus held after stop", pat_o, held);
        end
        pulse_run();
        repeat (6) @(negedge clk);
        check(busy_o == 1'b1, "R3 program intact", 72'(busy_o), 72'd1);
        check(pat_o == WB || pat_o == WC, "R3 words intact", pat_o, WB);
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        check(busy_o == 1'b0, "R11 second stop", 72'(busy_o), 72'd0);

        finish_up();
    end

endmodule